// File: doc/BRIEF.md
# Two-Level SMI Status Aggregator with Mirror and Clearing Reads

This block collects system-management and wake events from two families of sources and reports them on two levels. Three general-purpose wakeup pins arrive asynchronously. Each pin is resynchronised and watched for a change in either direction. Three idle-timer timeout pulses arrive already synchronous to the clock. Each source has its own enable. An enabled event sets a sticky bit in a second-level status byte. Any sticky bit holds a single top-level summary bit, and that summary bit also drives the SMI output.

Software reads each status byte at one of two addresses. The mirror address returns the byte and changes nothing. The clearing address returns the same byte and, on the same clock edge, wipes that byte. The top-level summary drops once no second-level bit remains anywhere. If a source fires in the very cycle of a clearing read, the event wins and its bit stays set. Read data is combinational from the current state, so the data on a clearing read shows the status as it was before the clear.

Top module: `smi_status_agg`

## Requirements
- R1: After reset, every readable byte returns 00h and `smi_o` is 0.
- R2: A read with `rd_addr` = 3'b001 or 3'b101 returns the pin status byte. Bit 0, bit 1 and bit 2 belong to pins 0, 1 and 2. Bits 7:3 always read 0.
- R3: Pin n may set its status bit only while `pin_ctrl[n]` = 0 (direction is input) and `pin_ctrl[4+n]` = 1 (enabled). While either condition is not met, a change on the pin leaves the status unchanged.
- R4: An enabled input pin sets its status bit on a rising change and also on a falling change. The change is seen through a two-stage synchronizer, so the bit is set within four clock cycles.
- R5: A read with `rd_addr` = 3'b010 or 3'b110 returns the timer status byte. Bits 7, 6 and 5 are set by `tmr_expire[2]`, `[1]` and `[0]`, and each is gated by `tmr_ctrl` at the same bit position. Bits 4:0 always read 0.
- R6: A mirror read (`rd_addr` 3'b001 or 3'b010 with `rd_en` = 1) returns the status and leaves it unchanged.
- R7: A clearing read (`rd_addr` 3'b101 or 3'b110) returns the same value as the mirror read and clears that byte on the same clock edge. The top-level bit is cleared as well, unless the other byte still holds a set bit.
- R8: A read with `rd_addr` = 3'b000 or 3'b100 returns the top-level word. Bit 0 is the summary, and bits 7:1 read 0. The summary and `smi_o` are 1 exactly when some second-level bit is set.
- R9: An enabled event that arrives in the same cycle as a clearing read of its byte leaves its bit set. The summary also stays set.
- R10: Status bits are sticky. They stay set after the source returns to idle, until a clearing read removes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 3 | Asynchronous wakeup pins |
| pin_ctrl | input | 8 | Pin control byte: [6:4] enables, [2:0] direction (0 = input) |
| tmr_expire | input | 3 | Single-cycle idle-timer timeout pulses (video, device 3, device 2) |
| tmr_ctrl | input | 8 | Timer enable byte: [7:5] gate the timer status bits |
| rd_en | input | 1 | Read strobe; one cycle per read |
| rd_addr | input | 3 | Read address: [2] selects the clearing alias, [1:0] selects the byte |
| rd_data | output | 8 | Combinational read data |
| smi_o | output | 1 | SMI request, equal to the top-level summary |

## Verification
The assertions take `tmr_expire` to be a synchronous pulse. They take pin activity to enter only through the synchronizer. They take a clearing read to last exactly one cycle per access. The stimulus changes pins and control bytes on the falling clock edge. It pulses timers for a single cycle and holds `rd_en` for one cycle per read. It keeps every pin low across reset, so no false edge appears when reset is released.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int unsigned BYTE_W = 8;

  // byte selector in rd_addr[1:0]
  typedef enum logic [1:0] {
    SEL_TOP  = 2'b00,
    SEL_PIN  = 2'b01,
    SEL_TMR  = 2'b10,
    SEL_NONE = 2'b11
  } byte_sel_e;
endpackage

// File: rtl/smi_pin_edge.sv
module smi_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // either direction of change
  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/smi_sticky.sv
module smi_sticky #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  // a set in the clear cycle wins
  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = '0;
    q_d = q_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/smi_rd_mux.sv
module smi_rd_mux
  import smi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 3,
  parameter int unsigned NUM_TMR  = 3,
  parameter int unsigned TMR_LSB  = 5
) (
  input  logic [1:0]          sel_i,
  input  logic [NUM_PINS-1:0] pin_stat_i,
  input  logic [NUM_TMR-1:0]  tmr_stat_i,
  input  logic                top_i,
  output logic [BYTE_W-1:0]   data_o
);
  always_comb begin
    data_o = '0;
    unique case (byte_sel_e'(sel_i))
      SEL_TOP:  data_o[0] = top_i;
      SEL_PIN:  data_o[NUM_PINS-1:0] = pin_stat_i;
      SEL_TMR:  data_o[TMR_LSB +: NUM_TMR] = tmr_stat_i;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 3,
  parameter int unsigned NUM_TMR     = 3,
  parameter int unsigned PIN_EN_LSB  = 4,
  parameter int unsigned TMR_LSB     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [7:0]          pin_ctrl,
  input  logic [NUM_TMR-1:0]  tmr_expire,
  input  logic [7:0]          tmr_ctrl,
  input  logic                rd_en,
  input  logic [2:0]          rd_addr,
  output logic [7:0]          rd_data,
  output logic                smi_o
);
  localparam logic [7:0] PIN_USED = 8'(((1 << NUM_PINS) - 1) | (((1 << NUM_PINS) - 1) << PIN_EN_LSB));
  localparam logic [7:0] TMR_USED = 8'(((1 << NUM_TMR) - 1) << TMR_LSB);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // pin path
  logic [NUM_PINS-1:0] pin_edge;
  logic [NUM_PINS-1:0] pin_evt;
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    smi_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .pin_i  (pin_in[i]),
      .edge_o (pin_edge[i])
    );
    assign pin_evt[i] = pin_edge[i] & ~pin_ctrl[i] & pin_ctrl[PIN_EN_LSB + i];
  end

  // timer path
  logic [NUM_TMR-1:0] tmr_evt;
  assign tmr_evt = tmr_expire & tmr_ctrl[TMR_LSB +: NUM_TMR];

  // bits the block does not decode
  logic unused_ctrl;
  assign unused_ctrl = ^{pin_ctrl & ~PIN_USED, tmr_ctrl & ~TMR_USED};

  // read decode
  logic clr_pin, clr_tmr;
  always_comb begin
    clr_pin = rd_en & rd_addr[2] & (byte_sel_e'(rd_addr[1:0]) == SEL_PIN);
    clr_tmr = rd_en & rd_addr[2] & (byte_sel_e'(rd_addr[1:0]) == SEL_TMR);
  end

  // second level
  logic [NUM_PINS-1:0] stat1_q;
  logic [NUM_TMR-1:0]  stat2_q;

  smi_sticky #(.W(NUM_PINS)) u_stat_pin (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (pin_evt),
    .clr_i (clr_pin),
    .q_o   (stat1_q)
  );

  smi_sticky #(.W(NUM_TMR)) u_stat_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (tmr_evt),
    .clr_i (clr_tmr),
    .q_o   (stat2_q)
  );

  // top level
  logic top_q, top_d;
  always_comb begin
    top_d = top_q;
    if (clr_pin && (stat2_q == '0)) top_d = 1'b0;
    if (clr_tmr && (stat1_q == '0)) top_d = 1'b0;
    if ((|pin_evt) || (|tmr_evt))   top_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) top_q <= 1'b0;
    else            top_q <= top_d;
  end

  smi_rd_mux #(
    .NUM_PINS (NUM_PINS),
    .NUM_TMR  (NUM_TMR),
    .TMR_LSB  (TMR_LSB)
  ) u_mux (
    .sel_i      (rd_addr[1:0]),
    .pin_stat_i (stat1_q),
    .tmr_stat_i (stat2_q),
    .top_i      (top_q),
    .data_o     (rd_data)
  );

  assign smi_o = top_q;
endmodule

// File: rtl/smi_status_agg_chk.sv
module smi_status_agg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       smi_o,
  input logic [2:0] stat1,
  input logic [2:0] stat2,
  input logic       top,
  input logic [2:0] pin_evt,
  input logic [2:0] tmr_expire,
  input logic [7:0] tmr_ctrl
);
  // R2: reserved pin-status bits
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[1:0] == 2'b01) |-> (rd_data[7:3] == 5'd0));

  // R5: enabled video timeout lands in bit 7
  a_r5_video_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire[2] && tmr_ctrl[7]) |=> stat2[2]);

  // R6: mirror read with no new event leaves status alone
  a_r6_mirror_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'b001 && pin_evt == 3'd0) |=> $stable(stat1));

  // R7: clearing read with no new event empties the byte
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'b101 && pin_evt == 3'd0) |=> (stat1 == 3'd0));

  // R8: summary tracks second level in both directions
  a_r8_top_implies_bits: assert property (@(posedge clk) disable iff (!rst_n)
    top |-> (stat1 != 3'd0 || stat2 != 3'd0));
  a_r8_bits_imply_top: assert property (@(posedge clk) disable iff (!rst_n)
    (stat1 != 3'd0 || stat2 != 3'd0) |-> (top && smi_o));

  // R9: event beats a concurrent clear
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_evt[0] && rd_en && rd_addr == 3'b101) |=> stat1[0]);
endmodule

bind smi_status_agg smi_status_agg_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .smi_o      (smi_o),
  .stat1      (stat1_q),
  .stat2      (stat2_q),
  .top        (top_q),
  .pin_evt    (pin_evt),
  .tmr_expire (tmr_expire),
  .tmr_ctrl   (tmr_ctrl)
);

// File: tb/smi_status_agg_tb.sv
`timescale 1ns/1ps
module smi_status_agg_tb_top;
  logic       clk;
  logic       rst_n;
  logic [2:0] pin_in;
  logic [7:0] pin_ctrl;
  logic [2:0] tmr_expire;
  logic [7:0] tmr_ctrl;
  logic       rd_en;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       smi_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  smi_status_agg dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_ctrl(pin_ctrl),
    .tmr_expire(tmr_expire), .tmr_ctrl(tmr_ctrl), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .smi_o(smi_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle read; data sampled before the edge that may clear
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = 3'b000;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rd(3'b101, d); rd(3'b110, d);
  endtask

  task automatic toggle_pin(input int n);
    @(negedge clk);
    pin_in[n] = ~pin_in[n];
    idle(5);
  endtask

  task automatic pulse_tmr(input logic [2:0] v);
    @(negedge clk);
    tmr_expire = v;
    @(negedge clk);
    tmr_expire = 3'b000;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'b000, d); check("R1 top", d, 8'h00);
    rd(3'b001, d); check("R1 pin", d, 8'h00);
    rd(3'b010, d); check("R1 tmr", d, 8'h00);
    check("R1 smi", {7'd0, smi_o}, 8'h00);
  endtask

  task automatic t_pin_gate();
    logic [7:0] d;
    pin_ctrl = 8'h11;           // pin0 enabled but output
    toggle_pin(0);
    rd(3'b001, d); check("R3 dir output", d, 8'h00);
    pin_ctrl = 8'h00;           // input, disabled
    toggle_pin(0);
    rd(3'b001, d); check("R3 disabled", d, 8'h00);
    check("R3 smi quiet", {7'd0, smi_o}, 8'h00);
    pin_ctrl = 8'h10;           // input, enabled
    toggle_pin(0);
    rd(3'b001, d); check("R3 enabled", d, 8'h01);
    clear_all();
  endtask

  task automatic t_both_edges();
    logic [7:0] d;
    pin_ctrl = 8'h20;
    toggle_pin(1);              // rise
    rd(3'b101, d); check("R4 rise", d, 8'h02);
    toggle_pin(1);              // fall
    rd(3'b001, d); check("R4 fall", d, 8'h02);
    clear_all();
  endtask

  task automatic t_pin_map();
    logic [7:0] d;
    pin_ctrl = 8'h40;
    toggle_pin(2);
    rd(3'b001, d); check("R2 pin2 bit2, bits7:3 zero", d, 8'h04);
    pin_ctrl = 8'h00;
    toggle_pin(2);
    clear_all();
  endtask

  task automatic t_timers();
    logic [7:0] d;
    tmr_ctrl = 8'hA0;           // video and dev2 enabled only
    pulse_tmr(3'b111);
    idle(1);
    rd(3'b010, d); check("R5 gating/map", d, 8'hA0);
    idle(3);
    rd(3'b010, d); check("R10 sticky", d, 8'hA0);
    rd(3'b010, d); check("R6 mirror repeat", d, 8'hA0);
    rd(3'b000, d); check("R8 top word", d, 8'h01);
    check("R8 smi", {7'd0, smi_o}, 8'h01);
    tmr_ctrl = 8'h40;
    pulse_tmr(3'b010);
    idle(1);
    rd(3'b010, d); check("R5 dev3 bit6", d, 8'hE0);
    clear_all();
  endtask

  task automatic t_clear();
    logic [7:0] d;
    tmr_ctrl = 8'h80; pin_ctrl = 8'h10;
    pulse_tmr(3'b100);
    toggle_pin(0);
    rd(3'b110, d); check("R7 clear returns", d, 8'h80);
    rd(3'b010, d); check("R7 byte cleared", d, 8'h00);
    rd(3'b000, d); check("R7 top kept by other byte", d, 8'h01);
    rd(3'b101, d); check("R7 clear pin returns", d, 8'h01);
    rd(3'b000, d); check("R7 top cleared", d, 8'h00);
    check("R8 smi low", {7'd0, smi_o}, 8'h00);
    pin_ctrl = 8'h00; toggle_pin(0);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    tmr_ctrl = 8'hA0;
    pulse_tmr(3'b100);
    idle(1);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'b110; tmr_expire = 3'b001;
    #1 d = rd_data;
    check("R9 read before clear", d, 8'h80);
    @(negedge clk);
    rd_en = 1'b0; rd_addr = 3'b000; tmr_expire = 3'b000;
    rd(3'b010, d); check("R9 new event kept", d, 8'h20);
    check("R9 smi kept", {7'd0, smi_o}, 8'h01);
    clear_all();
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_in = 3'b000; pin_ctrl = 8'h00;
    tmr_expire = 3'b000; tmr_ctrl = 8'h00; rd_en = 1'b0; rd_addr = 3'b000;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_pin_gate();
    t_both_edges();
    t_pin_map();
    t_timers();
    t_clear();
    t_collision();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule